// File: doc/BRIEF.md
# Multi-Mode Redundant-Digit Multiplier

This block multiplies two multi-word operands held in a carry-pending redundant form. Each 17-bit word stands for a 16-bit digit plus one pending carry, and an operand's value is the sum of its words, each weighted by 2^(16·i). One datapath serves three operations, chosen by a one-hot mode input:

- a full squaring of operand A;
- a product A·B kept modulo 2^(16·NW), so only the lower half survives;
- a product A·B plus a double-width addend C, shifted right by 16·NW, so only the upper half survives.

A caller that sequences modular reductions issues one operation per cycle. The registered result appears one clock later. Partial products are grouped by column and summed in a tree of three-input adders.

In upper-half mode, carries from the columns below the cut are not propagated. Only the two guard words just below the cut are resolved. A flag reports when a dropped carry could still have crossed into the kept half, and the caller then repairs the result. The same flag reports bits lost above the top output word in squaring and upper-half mode. A mode input that does not have exactly one bit set produces a zero result and an error flag.

Top module: `rwm_mult`

## Requirements
- R1: While reset is asserted, `prod_o` is all zero and `ovf_o` and `err_o` are 0.
- R2: Outputs are registered. The result for the inputs sampled at one rising clock edge is visible after that edge and holds until the next one.
- R3: Word i of any operand or result occupies bits [17·i+16 : 17·i], and a vector's value is the sum of word_i·2^(16·i). Words may carry bit 16 set.
- R4: `mode_i` is one-hot: 3'b001 selects squaring, 3'b010 selects lower half, 3'b100 selects upper half with addend.
- R5: In squaring mode, `b_i` and `c_i` are ignored. `ovf_o` is 1 exactly when A² ≥ 2^(32·NW+1); otherwise the value of all 2·NW result words equals A².
- R6: In lower-half mode, the value of result words 0..NW-1 equals (A·B) mod 2^(16·NW). Words NW..2·NW-1 are zero, `ovf_o` is 0, and `c_i` is ignored.
- R7: In upper-half mode, words NW..2·NW-1 are zero. When `ovf_o` is 0, the value of words 0..NW-1 equals floor((A·B+C)/2^(16·NW)), where C is the 2·NW-word addend.
- R8: In upper-half mode, `ovf_o` is never 0 when the result differs from floor((A·B+C)/2^(16·NW)).
- R9: In upper-half mode, `ovf_o` is 0 whenever two conditions both hold. First, the exact 32-bit guard field, bits [16·NW-1 : 16·(NW-2)] of A·B+C, lies in [NW·2^19, 2^32 − NW·2^19). Second, the exact upper value is below 2^(16·NW+1).
- R10: A `mode_i` value without exactly one bit set gives a zero result, `ovf_o` 0 and `err_o` 1 in the next cycle. Any legal mode gives `err_o` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | One-hot operation select |
| a_i | input | NW·17 | Operand A, redundant words |
| b_i | input | NW·17 | Operand B, redundant words |
| c_i | input | 2·NW·17 | Addend for upper-half mode |
| prod_o | output | 2·NW·17 | Registered result words |
| ovf_o | output | 1 | Boundary carry possible or bits lost |
| err_o | output | 1 | Illegal mode was sampled |

## Verification
In upper-half mode, two independent conditions drive the same `ovf_o` bit: a guard field close enough to 2^32 that a dropped low carry might cross the cut, and bits lost above the top output word. All-ones operands (every word 0x1FFFF) raise the second condition, and often the first as well. A directed case uses zero operands, an addend whose guard words are all ones, and a full 0x1FFFF word below them; this raises only the first condition, and the dropped carry really changes the result. The reference model judges each case from the exact wide sum: a wrong result must carry the flag, and a guard in the safe band with a fitting result must not.

// File: rtl/rwm_pkg.sv
package rwm_pkg;

  localparam int DIG_W  = 16;
  localparam int RED_W  = 17;
  localparam int PROD_W = 2 * RED_W;

  localparam logic [2:0] MODE_SQ = 3'b001;
  localparam logic [2:0] MODE_LO = 3'b010;
  localparam logic [2:0] MODE_HI = 3'b100;

  // Product of two redundant words at full width.
  function automatic logic [PROD_W-1:0] word_mul(input logic [RED_W-1:0] x,
                                                 input logic [RED_W-1:0] y);
    return PROD_W'(x) * PROD_W'(y);
  endfunction

  // Number of three-input adder levels needed to reduce n terms to one.
  function automatic int clog3(input int n);
    int lvl;
    int cnt;
    lvl = 0;
    cnt = n;
    while (cnt > 1) begin
      cnt = (cnt + 2) / 3;
      lvl++;
    end
    return lvl;
  endfunction

  // Guard field is close enough to wrap that a dropped carry may cross the cut.
  function automatic logic guard_at_risk(input logic [31:0] guard,
                                         input logic [32:0] thresh);
    return {1'b0, guard} >= thresh;
  endfunction

endpackage

// File: rtl/rwm_add3_tree.sv
module rwm_add3_tree #(
  parameter int N = 5,
  parameter int W = 40
) (
  input  logic [N*W-1:0] terms_i,
  output logic [W-1:0]   sum_o
);
  localparam int LVL = rwm_pkg::clog3(N);
  localparam int PAD = 3 * N;

  logic [W-1:0] v [PAD];
  int unsigned  cnt;

  // Each level folds groups of three into one entry, in place.
  always_comb begin
    for (int i = 0; i < PAD; i++) begin
      v[i] = (i < N) ? terms_i[i*W +: W] : '0;
    end
    cnt = N;
    for (int l = 0; l < LVL; l++) begin
      for (int i = 0; i < N; i++) begin
        if (3 * i < cnt) begin
          v[i] = v[3*i]
               + ((3 * i + 1 < cnt) ? v[3*i+1] : '0)
               + ((3 * i + 2 < cnt) ? v[3*i+2] : '0);
        end
      end
      cnt = (cnt + 2) / 3;
    end
    sum_o = v[0];
  end

endmodule

// File: rtl/rwm_carry_ripple.sv
module rwm_carry_ripple #(
  parameter int NC = 4,
  parameter int CW = 40
) (
  input  logic [NC*CW-1:0]            cols_i,
  output logic [NC*rwm_pkg::DIG_W-1:0] dig_o,
  output logic [CW-1:0]               carry_o
);
  localparam int DW = rwm_pkg::DIG_W;

  logic [CW-1:0] acc;
  logic [CW-1:0] carry;

  always_comb begin
    carry = '0;
    acc   = '0;
    for (int k = 0; k < NC; k++) begin
      acc = cols_i[k*CW +: CW] + carry;
      dig_o[k*DW +: DW] = acc[DW-1:0];
      carry = acc >> DW;
    end
    carry_o = carry;
  end

endmodule

// File: rtl/rwm_mult.sv
module rwm_mult
  import rwm_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             mode_i,
  input  logic [NW*RED_W-1:0]    a_i,
  input  logic [NW*RED_W-1:0]    b_i,
  input  logic [2*NW*RED_W-1:0]  c_i,
  output logic [2*NW*RED_W-1:0]  prod_o,
  output logic                   ovf_o,
  output logic                   err_o
);
  localparam int NCOL  = 2 * NW;
  localparam int NTERM = NW + 1;
  localparam int CW    = PROD_W + $clog2(NTERM) + 1;
  localparam int NHI   = NW + 2;
  localparam int OUT_W = NCOL * RED_W;
  localparam int LO_W  = NW * RED_W;
  localparam logic [32:0] RISK_TH =
    33'(64'h1_0000_0000 - 64'(NW) * 64'h8_0000);

  // Mode decode
  logic legal, is_sq, is_lo, is_hi;
  assign legal = $onehot(mode_i);
  assign is_sq = legal && (mode_i == MODE_SQ);
  assign is_lo = legal && (mode_i == MODE_LO);
  assign is_hi = legal && (mode_i == MODE_HI);

  // Operand unpacking; squaring feeds A to both multiplier inputs
  logic [RED_W-1:0] aw   [NW];
  logic [RED_W-1:0] bsel [NW];
  logic [RED_W-1:0] cw   [NCOL];

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      aw[i]   = a_i[i*RED_W +: RED_W];
      bsel[i] = is_sq ? a_i[i*RED_W +: RED_W] : b_i[i*RED_W +: RED_W];
    end
    for (int k = 0; k < NCOL; k++) begin
      cw[k] = c_i[k*RED_W +: RED_W];
    end
  end

  // Column terms: every partial product of weight k, plus the addend word
  logic [NTERM*CW-1:0] col_terms [NCOL];

  always_comb begin
    for (int k = 0; k < NCOL; k++) begin
      col_terms[k] = '0;
      for (int i = 0; i < NW; i++) begin
        if ((k - i >= 0) && (k - i < NW)) begin
          col_terms[k][i*CW +: CW] = CW'(word_mul(aw[i], bsel[k-i]));
        end
      end
      col_terms[k][NW*CW +: CW] = is_hi ? CW'(cw[k]) : '0;
    end
  end

  logic [NCOL*CW-1:0] col_flat;

  for (genvar k = 0; k < NCOL; k++) begin : g_col
    rwm_add3_tree #(.N(NTERM), .W(CW)) u_tree (
      .terms_i (col_terms[k]),
      .sum_o   (col_flat[k*CW +: CW])
    );
  end

  // Exact ripple over all columns (squaring, lower half)
  logic [NCOL*DIG_W-1:0] full_dig;
  logic [CW-1:0]         full_carry;

  rwm_carry_ripple #(.NC(NCOL), .CW(CW)) u_full (
    .cols_i  (col_flat),
    .dig_o   (full_dig),
    .carry_o (full_carry)
  );

  // Truncated ripple from two guard columns below the cut (upper half)
  logic [NHI*DIG_W-1:0] hi_dig;
  logic [CW-1:0]        hi_carry;

  rwm_carry_ripple #(.NC(NHI), .CW(CW)) u_hi (
    .cols_i  (col_flat[NCOL*CW-1 : (NW-2)*CW]),
    .dig_o   (hi_dig),
    .carry_o (hi_carry)
  );

  // Named events
  logic [31:0] guard;
  logic        boundary_risk, sq_lost, hi_lost;
  assign guard         = hi_dig[2*DIG_W-1:0];
  assign boundary_risk = guard_at_risk(guard, RISK_TH);
  assign sq_lost       = |full_carry[CW-1:1];
  assign hi_lost       = |hi_carry[CW-1:1];

  // Result selection
  logic [OUT_W-1:0] nxt_prod;
  logic             nxt_ovf;

  always_comb begin
    nxt_prod = '0;
    nxt_ovf  = 1'b0;
    if (is_sq) begin
      for (int k = 0; k < NCOL; k++) begin
        nxt_prod[k*RED_W +: RED_W] = {1'b0, full_dig[k*DIG_W +: DIG_W]};
      end
      nxt_prod[OUT_W-1] = full_carry[0];
      nxt_ovf = sq_lost;
    end else if (is_lo) begin
      for (int k = 0; k < NW; k++) begin
        nxt_prod[k*RED_W +: RED_W] = {1'b0, full_dig[k*DIG_W +: DIG_W]};
      end
    end else if (is_hi) begin
      for (int k = 0; k < NW; k++) begin
        nxt_prod[k*RED_W +: RED_W] = {1'b0, hi_dig[(k+2)*DIG_W +: DIG_W]};
      end
      nxt_prod[LO_W-1] = hi_carry[0];
      nxt_ovf = boundary_risk | hi_lost;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o <= '0;
      ovf_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      prod_o <= nxt_prod;
      ovf_o  <= nxt_ovf;
      err_o  <= !legal;
    end
  end

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$onehot(mode_i) |=> (err_o && !ovf_o && prod_o == '0)); // R10
  AST_LEGAL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(mode_i) |=> !err_o); // R10
  AST_LO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_LO) |=> (!ovf_o && prod_o[OUT_W-1:LO_W] == '0)); // R6
  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_HI) |=> (prod_o[OUT_W-1:LO_W] == '0)); // R7
  AST_HI_RISK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_HI && (boundary_risk || hi_lost)) |=> ovf_o); // R8
  AST_SQ_LOST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_SQ && sq_lost) |=> ovf_o); // R5

endmodule

// File: tb/rwm_mult_bench.sv
`timescale 1ns/1ps
module rwm_mult_bench;
  localparam int NW   = 4;
  localparam int RED  = 17;
  localparam int NCOL = 2 * NW;
  localparam int AW   = NW * RED;
  localparam int ZW   = NCOL * RED;
  localparam int BW   = 160;
  localparam logic [BW-1:0] BOUNDV = BW'(NW) * BW'(32'h80000);
  localparam logic [BW-1:0] TWO32  = BW'(1) << 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = 3'b001;
  logic [AW-1:0] a = '0;
  logic [AW-1:0] b = '0;
  logic [ZW-1:0] c = '0;
  logic [ZW-1:0] prod_o;
  logic          ovf_o, err_o;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic [2:0]    m;
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    logic [ZW-1:0] c;
  } rec_t;
  rec_t q[$];

  always #10 clk = ~clk;

  rwm_mult #(.NW(NW)) u_rwm_mult (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .a_i(a), .b_i(b), .c_i(c),
    .prod_o(prod_o), .ovf_o(ovf_o), .err_o(err_o)
  );

  function automatic logic [BW-1:0] words_val(input logic [ZW-1:0] v, input int n);
    logic [BW-1:0] acc = '0;
    for (int i = 0; i < n; i++) acc += BW'(v[i*RED +: RED]) << (16 * i);
    return acc;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference for one queued operation, judged at the ports
  task automatic judge(input rec_t r);
    logic [BW-1:0] av, bv, cv, got, ex, up, g;
    logic [ZW-AW-1:0] upper_raw;
    logic eo;
    av = words_val(ZW'(r.a), NW);
    bv = words_val(ZW'(r.b), NW);
    cv = words_val(r.c, NCOL);
    got = words_val(prod_o, NCOL);
    upper_raw = prod_o[ZW-1:AW];
    if (!$onehot(r.m)) begin
      chk(err_o == 1'b1, "R10 err on illegal mode", BW'(err_o), 1);
      chk(prod_o == '0 && !ovf_o, "R10 zero on illegal mode", got, 0);
      return;
    end
    chk(err_o == 1'b0, "R2/R10 err clear on legal mode", BW'(err_o), 0);
    case (r.m)
      3'b001: begin
        ex = av * av;
        eo = ex >= (BW'(1) << (32 * NW + 1));
        chk(ovf_o == eo, "R4/R5 square overflow flag", BW'(ovf_o), BW'(eo));
        if (!eo) chk(got == ex, "R3/R5 square value", got, ex);
      end
      3'b010: begin
        ex = (av * bv) & ((BW'(1) << (16 * NW)) - 1);
        chk(got == ex, "R3/R4/R6 lower value", got, ex);
        chk(!ovf_o, "R6 lower flag", BW'(ovf_o), 0);
        chk(upper_raw == '0, "R6 lower upper words", BW'(upper_raw), 0);
      end
      default: begin
        ex = av * bv + cv;
        up = ex >> (16 * NW);
        g  = (ex >> (16 * (NW - 2))) & (TWO32 - 1);
        chk(upper_raw == '0, "R4/R7 upper words zero", BW'(upper_raw), 0);
        if (!ovf_o) chk(got == up, "R3/R7 upper value", got, up);
        if (got != up) chk(ovf_o, "R8 missed boundary carry", BW'(ovf_o), 1);
        if (g >= BOUNDV && g < TWO32 - BOUNDV && up < (BW'(1) << (16 * NW + 1)))
          chk(!ovf_o, "R9 spurious flag", BW'(ovf_o), 0);
      end
    endcase
  endtask

  task automatic apply(input logic [2:0] m, input logic [AW-1:0] av,
                       input logic [AW-1:0] bv, input logic [ZW-1:0] cv);
    rec_t r;
    @(negedge clk);
    if (q.size() > 0) judge(q.pop_front());
    mode = m; a = av; b = bv; c = cv;
    r.m = m; r.a = av; r.b = bv; r.c = cv;
    q.push_back(r);
  endtask

  function automatic logic [ZW-1:0] rnd_words(input int n);
    logic [ZW-1:0] v = '0;
    for (int i = 0; i < n; i++) v[i*RED +: RED] = 17'($urandom);
    return v;
  endfunction

  function automatic logic [ZW-1:0] fill_words(input int n, input logic [16:0] w);
    logic [ZW-1:0] v = '0;
    for (int i = 0; i < n; i++) v[i*RED +: RED] = w;
    return v;
  endfunction

  initial begin
    logic [ZW-1:0] gc;
    logic [AW-1:0] ones17, ones16;
    ones17 = AW'(fill_words(NW, 17'h1FFFF));
    ones16 = AW'(fill_words(NW, 17'h0FFFF));
    a = ones17;
    repeat (3) @(negedge clk);
    chk(prod_o == '0, "R1 reset result", words_val(prod_o, NCOL), 0);
    chk(!ovf_o && !err_o, "R1 reset flags", BW'({ovf_o, err_o}), 0);
    rst_n = 1'b1;

    apply(3'b001, ones16, AW'(rnd_words(NW)), rnd_words(NCOL));
    apply(3'b001, ones17, '0, '0);
    apply(3'b010, ones17, ones17, rnd_words(NCOL));
    apply(3'b100, ones17, ones17, fill_words(NCOL, 17'h1FFFF));
    // Guard words all ones with a full word below: dropped carry crosses the cut
    gc = '0;
    gc[(NW-3)*RED +: RED] = 17'h1FFFF;
    gc[(NW-2)*RED +: RED] = 17'h0FFFF;
    gc[(NW-1)*RED +: RED] = 17'h0FFFF;
    gc[NW*RED +: RED]     = 17'h00123;
    apply(3'b100, '0, '0, gc);
    apply(3'b000, ones17, ones17, '0);
    apply(3'b100, AW'(rnd_words(NW)), AW'(rnd_words(NW)), rnd_words(NCOL));
    apply(3'b011, ones17, ones17, '0);
    apply(3'b111, '0, '0, '0);
    apply(3'b010, AW'(rnd_words(NW)), AW'(rnd_words(NW)), rnd_words(NCOL));
    apply(3'b110, AW'(rnd_words(NW)), '0, '0);
    apply(3'b001, AW'(rnd_words(NW)), AW'(rnd_words(NW)), rnd_words(NCOL));
    for (int it = 0; it < 400; it++) begin
      logic [2:0] m;
      m = (it % 9 == 8) ? 3'($urandom) : 3'b001 << (it % 3);
      apply(m, AW'(rnd_words(NW)), AW'(rnd_words(NW)), rnd_words(NCOL));
    end
    @(negedge clk);
    if (q.size() > 0) judge(q.pop_front());
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule